// File: doc/BRIEF.md
# Event Assignment Routing Engine

This block routes forwarded interrupt-style events to their consumers. Each incoming event carries a source number. The source number indexes an assignment table. A valid, unmasked assignment entry names a notification descriptor and supplies 31 bits of event data. The descriptor supplies two things:

- a circular in-memory event queue, which receives one data word per routed event;
- a processor target with one of eight priority levels, which is notified once that word has been written.

Software fills both tables through two configuration write ports. The block handles one event at a time. It accepts an event, issues the queue write, and waits for the memory acknowledge. It then presents the notification and waits for the downstream presentation stage to take it. Only after that handshake does it take the next event.

Each descriptor keeps its own write index and generation bit. Software can therefore tell fresh queue words from stale ones after the queue wraps.

Top module: `evt_router`

## Requirements
- R1: After reset, `evt_ready_o` is 1 while `mem_req_o` and `ntf_valid_o` are 0.
- R2: An event accepted from a source whose entry is valid and unmasked produces one memory write. The write address is `{base, 2'b00} + 4 * write_index` of the descriptor the entry names. The write data is `{generation, event_data[30:0]}`.
- R3: An event from a source whose entry is invalid or masked is dropped. It causes no memory write and no notification, and `evt_ready_o` stays 1.
- R4: Each routed event advances its descriptor's write index by one. When the index equals `2^log2_size - 1`, it returns to 0 and the generation bit inverts. A log2 size of 0 therefore wraps on every event.
- R5: The notification carries the descriptor's target and 3-bit priority. It is raised in the cycle after the memory write is acknowledged and never earlier. Write and notification are never active together.
- R6: `mem_req_o` holds with stable address and data until `mem_ack_i`. `ntf_valid_o` holds with stable target and priority until `ntf_ready_i`.
- R7: `evt_ready_o` is 0 from the cycle after a routed event is accepted until the notification handshake completes.
- R8: Several sources that name the same descriptor share its queue. Their writes take consecutive indices in arrival order.
- R9: Writing a descriptor through the configuration port sets its write index to 0 and its generation bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event present |
| evt_src_i | input | SRC_W | Source number of the event |
| evt_ready_o | output | 1 | Block idle, event accepted when valid |
| cfg_asgn_we_i | input | 1 | Assignment entry write strobe |
| cfg_asgn_idx_i | input | SRC_W | Assignment entry to write |
| cfg_asgn_valid_i | input | 1 | Entry valid |
| cfg_asgn_mask_i | input | 1 | Entry masked |
| cfg_asgn_desc_i | input | DESC_W | Descriptor named by the entry |
| cfg_asgn_data_i | input | 31 | Event data placed in queue words |
| cfg_desc_we_i | input | 1 | Descriptor write strobe |
| cfg_desc_idx_i | input | DESC_W | Descriptor to write |
| cfg_desc_base_i | input | ADDR_W-2 | Queue base as a word address |
| cfg_desc_log2_i | input | LOG_W | log2 of queue entries, at most QIDX_W |
| cfg_desc_tgt_i | input | TGT_W | Notification target |
| cfg_desc_prio_i | input | 3 | Notification priority |
| mem_req_o | output | 1 | Queue write request |
| mem_addr_o | output | ADDR_W | Queue write byte address |
| mem_data_o | output | 32 | Queue write data |
| mem_ack_i | input | 1 | Queue write accepted |
| ntf_valid_o | output | 1 | Notification present |
| ntf_tgt_o | output | TGT_W | Notification target |
| ntf_prio_o | output | 3 | Notification priority |
| ntf_ready_i | input | 1 | Notification accepted |

## Verification
The bench first sends repeated events from one source into a four-entry queue. It then sends events from a second source that names the same descriptor. Together these separate a correct shared write index from a per-source one, and they show the wrap and generation flip at the fourth write.

A one-entry queue must flip its generation bit on every event. Events from a masked source and an invalid source separate the two discard paths from routing. A descriptor is rewritten mid-run to show that its index and generation restart.

Memory and notification acknowledges are stalled for zero, one or two cycles. This exposes any write and notification ordering fault, and any output that does not hold while it waits.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int unsigned PRIO_W  = 3;
  localparam int unsigned EDATA_W = 31;
  localparam int unsigned QWORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_NOTIFY = 2'd2
  } rt_state_e;
endpackage

// File: rtl/evt_asgn_tbl.sv
module evt_asgn_tbl
  import evt_router_pkg::*;
#(
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned DESC_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SRC_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic               wr_mask_i,
  input  logic [DESC_W-1:0]  wr_desc_i,
  input  logic [EDATA_W-1:0] wr_data_i,
  input  logic [SRC_W-1:0]   rd_idx_i,
  output logic               rd_hit_o,
  output logic [DESC_W-1:0]  rd_desc_o,
  output logic [EDATA_W-1:0] rd_data_o
);
  localparam int unsigned N_SRC = 1 << SRC_W;

  logic               valid_q [N_SRC];
  logic               mask_q  [N_SRC];
  logic [DESC_W-1:0]  desc_q  [N_SRC];
  logic [EDATA_W-1:0] data_q  [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        mask_q[i]  <= 1'b0;
        desc_q[i]  <= '0;
        data_q[i]  <= '0;
      end else if (we_i && wr_idx_i == SRC_W'(i)) begin
        valid_q[i] <= wr_valid_i;
        mask_q[i]  <= wr_mask_i;
        desc_q[i]  <= wr_desc_i;
        data_q[i]  <= wr_data_i;
      end
    end
  end

  assign rd_hit_o  = valid_q[rd_idx_i] && !mask_q[rd_idx_i];
  assign rd_desc_o = desc_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
endmodule

// File: rtl/evt_desc_tbl.sv
module evt_desc_tbl
  import evt_router_pkg::*;
#(
  parameter int unsigned DESC_W = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QIDX_W = 15,
  parameter int unsigned TGT_W  = 6,
  localparam int unsigned LOG_W = $clog2(QIDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DESC_W-1:0] wr_idx_i,
  input  logic [ADDR_W-3:0] wr_base_i,
  input  logic [LOG_W-1:0]  wr_log2_i,
  input  logic [TGT_W-1:0]  wr_tgt_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic              adv_i,
  input  logic [DESC_W-1:0] adv_idx_i,
  input  logic [DESC_W-1:0] rd_idx_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_gen_o,
  output logic [TGT_W-1:0]  rd_tgt_o,
  output logic [PRIO_W-1:0] rd_prio_o
);
  localparam int unsigned N_DESC = 1 << DESC_W;

  logic [ADDR_W-3:0] base_q [N_DESC];
  logic [LOG_W-1:0]  log2_q [N_DESC];
  logic [QIDX_W-1:0] widx_q [N_DESC];
  logic              gen_q  [N_DESC];
  logic [TGT_W-1:0]  tgt_q  [N_DESC];
  logic [PRIO_W-1:0] prio_q [N_DESC];

  for (genvar i = 0; i < N_DESC; i++) begin : g_ent
    logic [QIDX_W-1:0] lim;
    assign lim = ~({QIDX_W{1'b1}} << log2_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i] <= '0;
        log2_q[i] <= '0;
        widx_q[i] <= '0;
        gen_q[i]  <= 1'b1;
        tgt_q[i]  <= '0;
        prio_q[i] <= '0;
      end else if (we_i && wr_idx_i == DESC_W'(i)) begin
        base_q[i] <= wr_base_i;
        log2_q[i] <= wr_log2_i;
        widx_q[i] <= '0;
        gen_q[i]  <= 1'b1;
        tgt_q[i]  <= wr_tgt_i;
        prio_q[i] <= wr_prio_i;
      end else if (adv_i && adv_idx_i == DESC_W'(i)) begin
        if (widx_q[i] == lim) begin
          widx_q[i] <= '0;
          gen_q[i]  <= ~gen_q[i];
        end else begin
          widx_q[i] <= widx_q[i] + 1'b1;
        end
      end
    end
  end

  assign rd_addr_o = {base_q[rd_idx_i], 2'b00} + ADDR_W'({widx_q[rd_idx_i], 2'b00});
  assign rd_gen_o  = gen_q[rd_idx_i];
  assign rd_tgt_o  = tgt_q[rd_idx_i];
  assign rd_prio_o = prio_q[rd_idx_i];
endmodule

// File: rtl/evt_route_ctrl.sv
module evt_route_ctrl
  import evt_router_pkg::*;
#(
  parameter int unsigned DESC_W = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TGT_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  output logic               evt_ready_o,
  input  logic               hit_i,
  input  logic [EDATA_W-1:0] ev_data_i,
  input  logic [DESC_W-1:0]  desc_idx_i,
  input  logic [ADDR_W-1:0]  q_addr_i,
  input  logic               q_gen_i,
  input  logic [TGT_W-1:0]   tgt_i,
  input  logic [PRIO_W-1:0]  prio_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [QWORD_W-1:0] mem_data_o,
  input  logic               mem_ack_i,
  output logic               ntf_valid_o,
  output logic [TGT_W-1:0]   ntf_tgt_o,
  output logic [PRIO_W-1:0]  ntf_prio_o,
  input  logic               ntf_ready_i,
  output logic               adv_o,
  output logic [DESC_W-1:0]  adv_idx_o
);
  rt_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      ntf_tgt_o  <= '0;
      ntf_prio_o <= '0;
      adv_idx_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (evt_valid_i && hit_i) begin
          // latch everything at accept so outputs stay put while stalled
          state_q    <= ST_WRITE;
          mem_addr_o <= q_addr_i;
          mem_data_o <= {q_gen_i, ev_data_i};
          ntf_tgt_o  <= tgt_i;
          ntf_prio_o <= prio_i;
          adv_idx_o  <= desc_idx_i;
        end
        ST_WRITE:  if (mem_ack_i) state_q <= ST_NOTIFY;
        ST_NOTIFY: if (ntf_ready_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign evt_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_WRITE);
  assign ntf_valid_o = (state_q == ST_NOTIFY);
  assign adv_o       = mem_req_o && mem_ack_i;
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_router_pkg::*;
#(
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned DESC_W = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QIDX_W = 15,
  parameter int unsigned TGT_W  = 6,
  localparam int unsigned LOG_W = $clog2(QIDX_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [SRC_W-1:0]   evt_src_i,
  output logic               evt_ready_o,
  input  logic               cfg_asgn_we_i,
  input  logic [SRC_W-1:0]   cfg_asgn_idx_i,
  input  logic               cfg_asgn_valid_i,
  input  logic               cfg_asgn_mask_i,
  input  logic [DESC_W-1:0]  cfg_asgn_desc_i,
  input  logic [30:0]        cfg_asgn_data_i,
  input  logic               cfg_desc_we_i,
  input  logic [DESC_W-1:0]  cfg_desc_idx_i,
  input  logic [ADDR_W-3:0]  cfg_desc_base_i,
  input  logic [LOG_W-1:0]   cfg_desc_log2_i,
  input  logic [TGT_W-1:0]   cfg_desc_tgt_i,
  input  logic [2:0]         cfg_desc_prio_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [31:0]        mem_data_o,
  input  logic               mem_ack_i,
  output logic               ntf_valid_o,
  output logic [TGT_W-1:0]   ntf_tgt_o,
  output logic [2:0]         ntf_prio_o,
  input  logic               ntf_ready_i
);
  logic               hit;
  logic [DESC_W-1:0]  desc_idx;
  logic [EDATA_W-1:0] ev_data;
  logic [ADDR_W-1:0]  q_addr;
  logic               q_gen;
  logic [TGT_W-1:0]   q_tgt;
  logic [PRIO_W-1:0]  q_prio;
  logic               adv;
  logic [DESC_W-1:0]  adv_idx;

  evt_asgn_tbl #(.SRC_W(SRC_W), .DESC_W(DESC_W)) u_asgn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_asgn_we_i),
    .wr_idx_i   (cfg_asgn_idx_i),
    .wr_valid_i (cfg_asgn_valid_i),
    .wr_mask_i  (cfg_asgn_mask_i),
    .wr_desc_i  (cfg_asgn_desc_i),
    .wr_data_i  (cfg_asgn_data_i),
    .rd_idx_i   (evt_src_i),
    .rd_hit_o   (hit),
    .rd_desc_o  (desc_idx),
    .rd_data_o  (ev_data)
  );

  evt_desc_tbl #(.DESC_W(DESC_W), .ADDR_W(ADDR_W), .QIDX_W(QIDX_W), .TGT_W(TGT_W)) u_desc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_desc_we_i),
    .wr_idx_i  (cfg_desc_idx_i),
    .wr_base_i (cfg_desc_base_i),
    .wr_log2_i (cfg_desc_log2_i),
    .wr_tgt_i  (cfg_desc_tgt_i),
    .wr_prio_i (cfg_desc_prio_i),
    .adv_i     (adv),
    .adv_idx_i (adv_idx),
    .rd_idx_i  (desc_idx),
    .rd_addr_o (q_addr),
    .rd_gen_o  (q_gen),
    .rd_tgt_o  (q_tgt),
    .rd_prio_o (q_prio)
  );

  evt_route_ctrl #(.DESC_W(DESC_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .evt_ready_o (evt_ready_o),
    .hit_i       (hit),
    .ev_data_i   (ev_data),
    .desc_idx_i  (desc_idx),
    .q_addr_i    (q_addr),
    .q_gen_i     (q_gen),
    .tgt_i       (q_tgt),
    .prio_i      (q_prio),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_ack_i   (mem_ack_i),
    .ntf_valid_o (ntf_valid_o),
    .ntf_tgt_o   (ntf_tgt_o),
    .ntf_prio_o  (ntf_prio_o),
    .ntf_ready_i (ntf_ready_i),
    .adv_o       (adv),
    .adv_idx_o   (adv_idx)
  );
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TGT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_data_o,
  input logic              mem_ack_i,
  input logic              ntf_valid_o,
  input logic [TGT_W-1:0]  ntf_tgt_o,
  input logic [2:0]        ntf_prio_o,
  input logic              ntf_ready_i
);
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R6
  AST_NTF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o && !ntf_ready_i |=> ntf_valid_o && $stable(ntf_tgt_o) && $stable(ntf_prio_o)); // R6
  AST_WR_THEN_NTF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> ntf_valid_o); // R5
  AST_NTF_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ntf_valid_o) |-> $past(mem_req_o && mem_ack_i)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && ntf_valid_o)); // R5
  AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || ntf_valid_o) |-> !evt_ready_o); // R7
  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2
endmodule

bind evt_router evt_router_chk #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_ready_o (evt_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_ack_i   (mem_ack_i),
  .ntf_valid_o (ntf_valid_o),
  .ntf_tgt_o   (ntf_tgt_o),
  .ntf_prio_o  (ntf_prio_o),
  .ntf_ready_i (ntf_ready_i)
);

// File: tb/evt_router_bench.sv
`timescale 1ns/1ps
module evt_router_bench;
  localparam int SRC_W = 4, DESC_W = 3, ADDR_W = 32, QIDX_W = 15, TGT_W = 6;
  localparam int LOG_W = $clog2(QIDX_W + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic evt_valid_i = 1'b0;
  logic [SRC_W-1:0] evt_src_i = '0;
  logic evt_ready_o;
  logic cfg_asgn_we_i = 1'b0, cfg_asgn_valid_i = 1'b0, cfg_asgn_mask_i = 1'b0;
  logic [SRC_W-1:0] cfg_asgn_idx_i = '0;
  logic [DESC_W-1:0] cfg_asgn_desc_i = '0;
  logic [30:0] cfg_asgn_data_i = '0;
  logic cfg_desc_we_i = 1'b0;
  logic [DESC_W-1:0] cfg_desc_idx_i = '0;
  logic [ADDR_W-3:0] cfg_desc_base_i = '0;
  logic [LOG_W-1:0] cfg_desc_log2_i = '0;
  logic [TGT_W-1:0] cfg_desc_tgt_i = '0;
  logic [2:0] cfg_desc_prio_i = '0;
  logic mem_req_o, mem_ack_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic ntf_valid_o, ntf_ready_i = 1'b0;
  logic [TGT_W-1:0] ntf_tgt_o;
  logic [2:0] ntf_prio_o;

  always #2 clk_i = ~clk_i;

  evt_router u_evt_router (.*);

  int checks = 0, failures = 0;
  int mem_done = 0, ntf_done = 0;

  // reference tables built from the requirements
  bit          a_v [16], a_m [16];
  int          a_d [16];
  logic [30:0] a_data [16];
  logic [29:0] d_base [8];
  int          d_log [8], d_idx [8], d_tgt [8], d_prio [8];
  bit          d_gen [8];

  logic [63:0] exp_mem [$];
  logic [8:0]  exp_ntf [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_asgn(input int idx, input bit v, input bit m, input int d, input logic [30:0] data);
    @(negedge clk_i);
    cfg_asgn_we_i = 1'b1; cfg_asgn_idx_i = SRC_W'(idx); cfg_asgn_valid_i = v;
    cfg_asgn_mask_i = m; cfg_asgn_desc_i = DESC_W'(d); cfg_asgn_data_i = data;
    a_v[idx] = v; a_m[idx] = m; a_d[idx] = d; a_data[idx] = data;
    @(negedge clk_i);
    cfg_asgn_we_i = 1'b0;
  endtask

  task automatic cfg_desc(input int idx, input logic [29:0] base, input int lg, input int tgt, input int prio);
    @(negedge clk_i);
    cfg_desc_we_i = 1'b1; cfg_desc_idx_i = DESC_W'(idx); cfg_desc_base_i = base;
    cfg_desc_log2_i = LOG_W'(lg); cfg_desc_tgt_i = TGT_W'(tgt); cfg_desc_prio_i = 3'(prio);
    d_base[idx] = base; d_log[idx] = lg; d_idx[idx] = 0; d_gen[idx] = 1'b1;
    d_tgt[idx] = tgt; d_prio[idx] = prio;
    @(negedge clk_i);
    cfg_desc_we_i = 1'b0;
  endtask

  // driver: pushes expected write and notification, then offers the event
  task automatic send(input int src);
    bit routed;
    int d;
    logic [31:0] addr;
    @(negedge clk_i);
    while (!evt_ready_o) @(negedge clk_i);
    routed = a_v[src] && !a_m[src];
    if (routed) begin
      d = a_d[src];
      addr = {d_base[d], 2'b00} + 32'(d_idx[d] * 4);
      exp_mem.push_back({addr, d_gen[d], a_data[src]});
      exp_ntf.push_back({TGT_W'(d_tgt[d]), 3'(d_prio[d])});
      if (d_idx[d] == (1 << d_log[d]) - 1) begin
        d_idx[d] = 0; d_gen[d] = ~d_gen[d];
      end else d_idx[d]++;
    end
    evt_valid_i = 1'b1; evt_src_i = SRC_W'(src);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    if (routed) chk(evt_ready_o == 1'b0, "R7 busy after accept", 64'(evt_ready_o), 64'd0);
    else        chk(evt_ready_o == 1'b1, "R3 dropped event keeps ready", 64'(evt_ready_o), 64'd1);
  endtask

  // memory responder and monitor, stalls 0..2 cycles
  initial begin
    int stall = 0, wcnt = 0;
    logic [63:0] e;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (wcnt >= stall) begin
          mem_ack_i = 1'b1;
          if (exp_mem.size() == 0)
            chk(1'b0, "R3 unexpected memory write", {mem_addr_o, mem_data_o}, 64'd0);
          else begin
            e = exp_mem.pop_front();
            chk({mem_addr_o, mem_data_o} == e, "R2/R4/R8/R9 queue write", {mem_addr_o, mem_data_o}, e);
          end
          mem_done++;
          stall = (stall + 1) % 3; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  // notification responder and monitor
  initial begin
    int stall = 2, wcnt = 0;
    logic [8:0] e;
    forever begin
      @(negedge clk_i);
      ntf_ready_i = 1'b0;
      if (ntf_valid_o) begin
        if (wcnt >= stall) begin
          ntf_ready_i = 1'b1;
          chk(ntf_done < mem_done, "R5 notify after write", 64'(ntf_done), 64'(mem_done));
          if (exp_ntf.size() == 0)
            chk(1'b0, "R3 unexpected notification", {ntf_tgt_o, ntf_prio_o}, 64'd0);
          else begin
            e = exp_ntf.pop_front();
            chk({ntf_tgt_o, ntf_prio_o} == e, "R5 target and priority", {ntf_tgt_o, ntf_prio_o}, e);
          end
          ntf_done++;
          stall = (stall + 2) % 3; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(evt_ready_o == 1'b1, "R1 reset ready", 64'(evt_ready_o), 64'd1);
    chk(mem_req_o == 1'b0, "R1 reset mem_req", 64'(mem_req_o), 64'd0);
    chk(ntf_valid_o == 1'b0, "R1 reset ntf_valid", 64'(ntf_valid_o), 64'd0);

    cfg_desc(0, 30'h0000_0400, 2, 5, 3);
    cfg_desc(1, 30'h0000_0800, 0, 9, 0);
    cfg_desc(7, 30'h2000_0000, 3, 63, 7);
    cfg_asgn(0, 1, 0, 0, 31'h5EAD_BEEF);
    cfg_asgn(1, 1, 0, 0, 31'h1234_5678);
    cfg_asgn(2, 1, 1, 1, 31'h0000_00AA);
    cfg_asgn(3, 0, 0, 1, 31'h0000_00BB);
    cfg_asgn(4, 1, 0, 1, 31'h0000_0001);
    cfg_asgn(15, 1, 0, 7, 31'h7FFF_FFFF);

    // R2 R4 R8: two sources share descriptor 0, wrap at the fourth write
    for (int k = 0; k < 3; k++) send(0);
    for (int k = 0; k < 3; k++) send(1);
    // R3: masked and invalid sources
    send(2);
    send(3);
    // R4: single-entry queue flips generation each time
    for (int k = 0; k < 3; k++) send(4);
    for (int k = 0; k < 2; k++) send(15);
    // R9: rewrite descriptor 0, index and generation restart
    cfg_desc(0, 30'h0000_0400, 2, 5, 3);
    send(0);
    send(2);
    send(1);

    @(negedge clk_i);
    while (!evt_ready_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(exp_mem.size() == 0, "R2 all queue writes seen", 64'(exp_mem.size()), 64'd0);
    chk(exp_ntf.size() == 0, "R5 all notifications seen", 64'(exp_ntf.size()), 64'd0);
  endtask

  initial begin
    bit timeout = 1'b0;
    fork
      run_all();
      begin repeat (20000) @(posedge clk_i); timeout = 1'b1; end
    join_any
    if (timeout) chk(1'b0, "watchdog", 64'd1, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule